// File: doc/BRIEF.md
# Value-Reuse Multiply Lane

This lane multiplies one stationary signed operand by a row segment of signed 8-bit weights and places one 16-bit product per weight into a local result buffer. The weights are quantized, so a segment holds few distinct magnitudes. A product cache with one slot per magnitude, each slot with a valid bit, lets only the first appearance of a magnitude use the three-stage multiplier. Every later appearance takes the cached product, negates it when the weight is negative, and skips the multiplier entirely.

Software loads the weight buffer while the lane is idle and pulses `start` with the operand on `op_in`. The lane then fetches one weight per cycle. A repeat of a magnitude whose multiply is still in flight holds fetch until the cache slot is filled. Results from the cache path and the multiply path meet in a small write queue in front of the result buffer, so two results that arrive in the same cycle are written one after the other. Once the queue has drained, `done` pulses and all valid bits are cleared. The results are then read through a combinational read port.

Top module: `reuse_lane`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A write on the load port stores `wr_data` at `wr_addr` while the lane is idle. A load issued while `busy` is high has no effect on the stored weights.
- R3: `start` while idle captures `op_in` and raises `busy` on the next edge. A `start` while busy is ignored: neither the operand nor the timing of the run in progress changes.
- R4: Result entry i equals op_in × w[i], with w[i] read as two's complement. The code -128 is treated as -127, so its result is -127 × op_in.
- R5: The cache slot index is the weight magnitude (0..127), so a weight and its negative share a slot. A weight whose slot is invalid is multiplied, and that product fills the slot. A weight whose slot is valid never enters the multiplier.
- R6: With no stall, weights are fetched one per cycle in address order. A miss fetched at edge t enters the write queue at edge t+4, and a hit fetched at edge t enters it at edge t+2.
- R7: If a magnitude is still in one of the three multiply stages when a repeat of it is ready to issue, the repeat and all fetching are held. The repeat issues as a hit at the first edge after the slot is filled.
- R8: Each edge moves at most one queued result into the result buffer, oldest first. The queue never holds more than its depth of 4.
- R9: `done` is a one-cycle pulse, raised the edge after the last result buffer write, and `busy` falls on that same edge.
- R10: All valid bits are cleared on completion, so a following run with a new operand yields products of the new operand only.
- R11: `rd_data` shows result entry `rd_addr` combinationally as a 16-bit signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight buffer write strobe |
| wr_addr | input | 6 | Weight buffer write address |
| wr_data | input | 8 | Signed weight to store |
| op_in | input | 8 | Signed stationary operand, captured on start |
| start | input | 1 | Begin a run over all 64 weights |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | 6 | Result buffer read address |
| rd_data | output | 16 | Signed product at rd_addr |

## Verification
A miss reaches the write queue four edges after its fetch and a hit two edges after, a stalled repeat issues four edges after its first occurrence issued, and each result lands in the buffer one queue pop later. The bench replays those rules for each weight segment in a behavioural model built on integer timelines. From the model it derives the exact edge at which `done` must pulse. It then compares `busy` and `done` on every clock between the falling edges, from the start edge to two cycles past completion. Products are read back only after `done`, through the combinational read port, one settle step after each address change.

// File: rtl/reuse_lane.sv
module reuse_lane #(
  parameter int WW      = 8,
  parameter int XW      = 8,
  parameter int PW      = 16,
  parameter int DEPTH   = 64,
  parameter int MUL_LAT = 3,
  parameter int QAW     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WW-1:0]            wr_data,
  input  logic [XW-1:0]            op_in,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [PW-1:0]            rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int MW = WW - 1;
  localparam int CE = 1 << MW;
  localparam int QD = 1 << QAW;
  localparam logic [AW:0] PEND = (AW+1)'(DEPTH);

  logic signed [WW-1:0] wbuf  [DEPTH];
  logic signed [PW-1:0] obuf  [DEPTH];
  logic signed [PW-1:0] cache [CE];
  logic [CE-1:0]        vflag;
  logic signed [XW-1:0] xreg;
  logic [AW:0]          ptr;

  logic          f_v, f_neg;
  logic [AW-1:0] f_idx;
  logic [MW-1:0] f_mag;

  logic [MUL_LAT-1:0]   m_v;
  logic                 m_neg  [MUL_LAT];
  logic [AW-1:0]        m_idx  [MUL_LAT];
  logic [MW-1:0]        m_mag  [MUL_LAT];
  logic signed [PW-1:0] m_prod [MUL_LAT];

  logic                 r_v;
  logic [AW-1:0]        r_idx;
  logic signed [PW-1:0] r_val;

  logic [AW-1:0]        q_idx [QD];
  logic signed [PW-1:0] q_val [QD];
  logic [QAW-1:0]       q_wp, q_rp;
  logic [QAW:0]         q_cnt;

  logic signed [WW-1:0] wcur;
  logic [MW-1:0]        wlow, wmag;
  logic signed [PW-1:0] mulp, cval, hv, mv;
  logic                 inflight, hit, stall, adv, miss, fetch, pop, drained;
  logic [1:0]           npush;

  assign wcur = wbuf[ptr[AW-1:0]];
  assign wlow = wcur[MW-1:0];
  assign wmag = !wcur[WW-1] ? wlow : (wlow == '0 ? '1 : (~wlow + MW'(1)));

  always_comb begin
    inflight = 1'b0;
    for (int i = 0; i < MUL_LAT; i++)
      if (m_v[i] && m_mag[i] == f_mag) inflight = 1'b1;
  end

  assign hit   = f_v && vflag[f_mag];
  assign stall = f_v && !vflag[f_mag] && inflight;
  assign adv   = f_v && !stall;
  assign miss  = adv && !hit;
  assign fetch = busy && ptr != PEND && (!f_v || adv);
  assign pop   = q_cnt != '0;
  assign npush = {1'b0, r_v} + {1'b0, m_v[MUL_LAT-1]};
  assign drained = ptr == PEND && !f_v && m_v == '0 && !r_v && q_cnt == '0;

  assign mulp = $signed({{(PW-MW){1'b0}}, f_mag}) * $signed({{(PW-XW){xreg[XW-1]}}, xreg});
  assign cval = cache[f_mag];
  assign hv   = f_neg ? -cval : cval;
  assign mv   = m_neg[MUL_LAT-1] ? -m_prod[MUL_LAT-1] : m_prod[MUL_LAT-1];
  assign rd_data = obuf[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ptr   <= '0;
      f_v   <= 1'b0;
      m_v   <= '0;
      r_v   <= 1'b0;
      vflag <= '0;
      q_wp  <= '0;
      q_rp  <= '0;
      q_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        ptr  <= '0;
      end
      if (fetch) begin
        f_v <= 1'b1;
        ptr <= ptr + (AW+1)'(1);
      end else if (adv) begin
        f_v <= 1'b0;
      end
      r_v <= hit;
      m_v <= {m_v[MUL_LAT-2:0], miss};
      if (m_v[MUL_LAT-1]) vflag[m_mag[MUL_LAT-1]] <= 1'b1;
      q_wp  <= q_wp + QAW'(npush);
      q_rp  <= q_rp + QAW'(pop);
      q_cnt <= q_cnt + (QAW+1)'(npush) - (QAW+1)'(pop);
      if (busy && drained) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        vflag <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !busy) wbuf[wr_addr] <= wr_data;
    if (start && !busy) xreg <= op_in;
    if (fetch) begin
      f_idx <= ptr[AW-1:0];
      f_neg <= wcur[WW-1];
      f_mag <= wmag;
    end
    r_idx <= f_idx;
    r_val <= hv;
    m_idx[0]  <= f_idx;
    m_neg[0]  <= f_neg;
    m_mag[0]  <= f_mag;
    m_prod[0] <= mulp;
    for (int i = 1; i < MUL_LAT; i++) begin
      m_idx[i]  <= m_idx[i-1];
      m_neg[i]  <= m_neg[i-1];
      m_mag[i]  <= m_mag[i-1];
      m_prod[i] <= m_prod[i-1];
    end
    if (m_v[MUL_LAT-1]) cache[m_mag[MUL_LAT-1]] <= m_prod[MUL_LAT-1];
    if (r_v) begin
      q_idx[q_wp] <= r_idx;
      q_val[q_wp] <= r_val;
    end
    if (m_v[MUL_LAT-1]) begin
      q_idx[q_wp + QAW'(r_v)] <= m_idx[MUL_LAT-1];
      q_val[q_wp + QAW'(r_v)] <= mv;
    end
    if (pop) obuf[q_idx[q_rp]] <= q_val[q_rp];
  end
endmodule

// File: rtl/reuse_lane_chk.sv
module reuse_lane_chk #(
  parameter int MW  = 7,
  parameter int ML  = 3,
  parameter int QAW = 2,
  parameter int XW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              f_v,
  input logic [MW-1:0]     f_mag,
  input logic [ML-1:0]     m_v,
  input logic [MW-1:0]     m_mag_first,
  input logic [MW-1:0]     m_mag_last,
  input logic [(1<<MW)-1:0] vflag,
  input logic [QAW:0]      q_cnt,
  input logic [XW-1:0]     xreg
);
  a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (QAW+1)'(1 << QAW));

  a_r9_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (q_cnt == '0 && !busy));

  a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vflag == '0);

  a_r5_hit_skips_mul: assert property (@(posedge clk) disable iff (!rst_n)
    (f_v && vflag[f_mag]) |=> !m_v[0]);

  a_r5_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
    m_v[ML-1] |=> vflag[$past(m_mag_last)]);

  a_r7_repeat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (f_v && m_v[0] && m_mag_first == f_mag && !vflag[f_mag]) |=> (f_v && !m_v[0]));

  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(xreg));
endmodule

bind reuse_lane reuse_lane_chk #(.MW(MW), .ML(MUL_LAT), .QAW(QAW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .f_v(f_v), .f_mag(f_mag), .m_v(m_v), .m_mag_first(m_mag[0]),
  .m_mag_last(m_mag[MUL_LAT-1]), .vflag(vflag), .q_cnt(q_cnt), .xreg(xreg)
);

// File: tb/reuse_lane_test.sv
module reuse_lane_test;
  localparam int CLK_P = 10;

  logic        clk, rst_n, wr_en, start, busy, done;
  logic [5:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, op_in;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int wts [64];

  reuse_lane uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_in(op_in), .start(start), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int weff(input int w);
    return (w == -128) ? -127 : w;
  endfunction

  // Timing model from R5 R6 R7 R8 R9: edges counted from the start edge (0).
  function automatic int model_done();
    int push [1024];
    int first [128];
    int f, d, m, occ, last;
    foreach (push[e]) push[e] = 0;
    foreach (first[i]) first[i] = -1;
    f = 1;
    for (int k = 0; k < 64; k++) begin
      d = f + 1;
      m = weff(wts[k]);
      if (m < 0) m = -m;
      if (first[m] >= 0) begin
        if (d < first[m] + 4) d = first[m] + 4;
        push[d+1]++;
      end else begin
        first[m] = d;
        push[d+3]++;
      end
      f = d;
    end
    occ = 0;
    last = 0;
    for (int e = 0; e < 1024; e++) begin
      if (occ > 0) begin
        occ--;
        last = e;
      end
      occ += push[e];
    end
    return last + 1;
  endfunction

  task automatic load_all();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 6'(i);
      wr_data = 8'(wts[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int x, input bit inject, input string tag);
    int dn;
    dn = model_done();
    @(negedge clk);
    start = 1'b1;
    op_in = 8'(x);
    for (int e = 0; e <= dn + 1; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 0) start = 1'b0;
      if (inject && e == 2) begin
        wr_en = 1'b1; wr_addr = 6'd63; wr_data = 8'd55;
        start = 1'b1; op_in = 8'(x + 3);
      end
      if (inject && e == 3) begin
        wr_en = 1'b0;
        start = 1'b0;
      end
      // R6 R7 R8 R9: busy/done compared against the model every clock
      check({tag, " R9 busy"}, int'(busy), (e < dn) ? 1 : 0);
      check({tag, " R9 done"}, int'(done), (e == dn) ? 1 : 0);
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rd_addr = 6'(i);
      #1;
      // R4 R11 products read back
      check({tag, " R4 product"}, int'($signed(rd_data)), x * weff(wts[i]));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s;
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0;
    wr_addr = '0; wr_data = '0; op_in = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);

    // R2 R5: ramp of values, magnitudes shared between signs
    for (int i = 0; i < 64; i++) wts[i] = i - 32;
    load_all();
    run(37, 1'b0, "ramp");

    // R7: one value repeated, second copy must stall
    for (int i = 0; i < 64; i++) wts[i] = 7;
    load_all();
    run(-9, 1'b0, "repeat");

    // R4: pseudo-random with -128, 127, 0 corners
    s = 12345;
    for (int i = 0; i < 64; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      wts[i] = ((s >> 16) % 9) * 29 - 116;
    end
    wts[0] = -128; wts[1] = 127; wts[2] = -128; wts[3] = 0; wts[5] = 127; wts[6] = -127;
    load_all();
    run(-128, 1'b0, "mixed");
    // R10: same weights, new operand after flags cleared
    run(101, 1'b0, "rerun");

    // R2 R3: load and start during a run are ignored
    for (int i = 0; i < 64; i++) wts[i] = (i % 5) - (i % 3) * 40;
    load_all();
    run(-77, 1'b1, "inject");
    run(5, 1'b0, "after-inject");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule